// File: doc/BRIEF.md
# Chaining AES-128 Round Key Generator

This block produces AES-128 round keys on the fly, one per clock, for an iterative round datapath. It holds a single 128-bit working key register. A load strobe places the secret key in that register as the primary key. Each round-advance strobe then replaces the register with the next expanded key. The block also reports which round the presented key belongs to. The substitution box is built inside the block from finite-field arithmetic, so no table memory is needed.

A mode flag selects what happens when the schedule moves past the last round. In mission operation the schedule starts again from the secret key, so every encryption sees the same eleven keys. In test operation (self-test, pattern generation or signature compaction) the last derived key stays in the register and serves as a new primary key. The key stream therefore keeps running without repeating the secret key's schedule.

Top module: `aes128_keychain`

## Requirements
- R1: After reset, `round_key` is all zeros and `round_idx` is 0.
- R2: When `load` is high at a clock edge, after that edge `round_key` equals `key_in` and `round_idx` is 0. This holds even when `advance` is high at the same edge.
- R3: When `advance` is high, `load` is low and `round_idx` is below 10, the index rises by one. The new `round_key` is the standard AES-128 expansion step applied to the current key. Word 0 occupies bits [127:96]. The round constant for the step that leaves index i is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for i = 0 to 9. Starting from the secret key, this gives the eleven keys of the standard AES-128 example.
- R4: With both `load` and `advance` low, `round_key` and `round_idx` keep their values.
- R5: In mission mode (`test_mode` = 0), `advance` at index 10 returns the index to 0 and loads `round_key` from `key_in`.
- R6: In test mode (`test_mode` = 1), `advance` at index 10 returns the index to 0 and leaves `round_key` at the tenth key, which becomes the new primary key. `key_in` has no effect on this step.
- R7: After any return to index 0, whether by load or by wrap, the next step uses round constant 01. Repeating a mission pass therefore reproduces the first round key.
- R8: `round_idx` never exceeds 10. In test mode it cycles 0 to 10 and back without end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | 128 | Secret cipher key |
| load | input | 1 | Take `key_in` as the primary key |
| advance | input | 1 | Step to the next round key |
| test_mode | input | 1 | 1 = chain past round ten, 0 = restart from the secret key |
| round_key | output | 128 | Key for the current round |
| round_idx | output | 4 | Round number of `round_key` (0 to 10) |

## Verification
On every cycle the assertions check the control behaviour:
- the index stays in range and steps by one;
- the key and index hold when idle;
- a load takes priority over an advance;
- each mode wraps as required, with the test-mode wrap leaving the key unchanged.

Only the bench scenarios can show that the arithmetic is right: they compare all eleven keys against the published example vector. The scenarios also show that the round constant restarts after a wrap or a load, and that an altered `key_in` is ignored at a test-mode wrap.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

   // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1.
   function automatic logic [7:0] gf_x2(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_x2(sh);
      end
      return acc;
   endfunction

   // Multiplicative inverse as a^254; zero maps to zero.
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] t;
      logic [7:0] r;
      t = a;
      r = 8'h01;
      for (int k = 1; k < 8; k++) begin
         t = gf_mul(t, t);
         r = gf_mul(r, t);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   // Round constant for the step leaving round index idx.
   function automatic logic [7:0] rc_for(input int idx);
      logic [7:0] rc;
      rc = 8'h01;
      for (int i = 0; i < 16; i++)
         if (i < idx) rc = gf_x2(rc);
      return rc;
   endfunction

endpackage

// File: rtl/aes_kx_sbox.sv
module aes_kx_sbox
   import aes_kx_pkg::*;
(
   input  logic [7:0] din,
   output logic [7:0] dout
);
   logic [7:0] inv;

   always_comb begin
      inv  = gf_inv(din);
      dout = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
   end
endmodule

// File: rtl/aes_kx_step.sv
module aes_kx_step #(
   parameter int KEY_W  = 128,
   parameter int WORD_W = 32,
   localparam int NWORD = KEY_W / WORD_W,
   localparam int NBYTE = WORD_W / 8
) (
   input  logic [KEY_W-1:0]  cur_key,
   input  logic [7:0]        rcon,
   output logic [KEY_W-1:0]  nxt_key
);
   logic [WORD_W-1:0] last_w;
   logic [WORD_W-1:0] rot_w;
   logic [WORD_W-1:0] sub_w;
   logic [WORD_W-1:0] old_w [NWORD];
   logic [WORD_W-1:0] new_w [NWORD];

   assign last_w = cur_key[WORD_W-1:0];
   assign rot_w  = {last_w[WORD_W-9:0], last_w[WORD_W-1 -: 8]};

   for (genvar b = 0; b < NBYTE; b++) begin : g_sub
      aes_kx_sbox u_sbox (
         .din  (rot_w[b*8 +: 8]),
         .dout (sub_w[b*8 +: 8])
      );
   end

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      // word 0 sits in the most significant slice
      assign old_w[w] = cur_key[KEY_W-1-w*WORD_W -: WORD_W];
      if (w == 0) begin : g_head
         assign new_w[w] = old_w[w] ^ sub_w ^ {rcon, {(WORD_W-8){1'b0}}};
      end else begin : g_tail
         assign new_w[w] = old_w[w] ^ new_w[w-1];
      end
      assign nxt_key[KEY_W-1-w*WORD_W -: WORD_W] = new_w[w];
   end
endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl #(
   parameter int NR = 10,
   localparam int IDX_W = $clog2(NR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             at_last,
   output logic             step
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

   assign at_last = (idx == LAST);
   assign step    = advance && !load && !at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    idx <= '0;
      else if (load)                 idx <= '0;
      else if (advance && at_last)   idx <= '0;
      else if (advance)              idx <= idx + 1'b1;
   end
endmodule

// File: rtl/aes128_keychain.sv
module aes128_keychain #(
   parameter int KEY_W  = 128,
   parameter int WORD_W = 32,
   parameter int NR     = 10,
   localparam int IDX_W = $clog2(NR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key_in,
   input  logic             load,
   input  logic             advance,
   input  logic             test_mode,
   output logic [KEY_W-1:0] round_key,
   output logic [IDX_W-1:0] round_idx
);
   import aes_kx_pkg::*;

   if (KEY_W != 128) begin : g_bad_key
      $error("aes128_keychain supports a 128-bit key only");
   end
   if (NR != 10) begin : g_bad_nr
      $error("aes128_keychain requires ten rounds");
   end
   if (KEY_W % WORD_W != 0) begin : g_bad_word
      $error("word width must divide key width");
   end

   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] key_step;
   logic [IDX_W-1:0] idx;
   logic             at_last;
   logic             step;
   logic [7:0]       rcon;

   aes_kx_ctrl #(.NR(NR)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (advance),
      .idx     (idx),
      .at_last (at_last),
      .step    (step)
   );

   always_comb rcon = rc_for(int'(idx));

   aes_kx_step #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_step (
      .cur_key (key_q),
      .rcon    (rcon),
      .nxt_key (key_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          key_q <= '0;
      else if (load)                       key_q <= key_in;
      else if (step)                       key_q <= key_step;
      else if (advance && at_last && !test_mode) key_q <= key_in;
   end

   assign round_key = key_q;
   assign round_idx = idx;
endmodule

// File: rtl/aes128_keychain_chk.sv
module aes128_keychain_chk #(
   parameter int KEY_W = 128,
   parameter int NR    = 10,
   localparam int IDX_W = $clog2(NR + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [KEY_W-1:0] key_in,
   input logic             load,
   input logic             advance,
   input logic             test_mode,
   input logic [KEY_W-1:0] round_key,
   input logic [IDX_W-1:0] round_idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_idx <= LAST);

   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (round_key == $past(key_in)) && (round_idx == '0));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(round_key) && $stable(round_idx));

   // R3
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && round_idx != LAST) |=> round_idx == $past(round_idx) + 1'b1);

   // R5
   mission_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && round_idx == LAST && !test_mode)
         |=> (round_idx == '0) && (round_key == $past(key_in)));

   // R6
   test_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && round_idx == LAST && test_mode)
         |=> (round_idx == '0) && $stable(round_key));
endmodule

bind aes128_keychain aes128_keychain_chk #(.KEY_W(KEY_W), .NR(NR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .key_in    (key_in),
   .load      (load),
   .advance   (advance),
   .test_mode (test_mode),
   .round_key (round_key),
   .round_idx (round_idx)
);

// File: tb/aes128_keychain_bench.sv
module aes128_keychain_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] key_in = '0;
   logic         load = 1'b0;
   logic         advance = 1'b0;
   logic         test_mode = 1'b0;
   logic [127:0] round_key;
   logic [3:0]   round_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [127:0] key;
      logic [3:0]   idx;
      bit           use_key;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   aes128_keychain u_aes128_keychain (
      .clk (clk), .rst_n (rst_n), .key_in (key_in), .load (load),
      .advance (advance), .test_mode (test_mode),
      .round_key (round_key), .round_idx (round_idx)
   );

   localparam logic [127:0] K = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   logic [127:0] ref_k [11];
   initial begin
      ref_k[0]  = K;
      ref_k[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
      ref_k[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
      ref_k[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
      ref_k[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
      ref_k[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
      ref_k[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
      ref_k[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
      ref_k[8]  = 128'head27321b58dbad2312bf5607f8d292f;
      ref_k[9]  = 128'hac7766f319fadc2128d12941575c006e;
      ref_k[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
   end

   function automatic void judge(bit ok, string tag, string act, string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endfunction

   // monitor: compare one cycle result shortly after each edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         judge(round_idx == e.idx, {e.tag, " idx"},
               $sformatf("%0d", round_idx), $sformatf("%0d", e.idx));
         if (e.use_key)
            judge(round_key == e.key, {e.tag, " key"},
                  $sformatf("%h", round_key), $sformatf("%h", e.key));
      end
   end

   task automatic drive(input bit ld, input bit adv, input bit tm,
                        input logic [127:0] kin, input logic [127:0] ek,
                        input logic [3:0] ei, input bit uk, input string tag);
      exp_t e;
      @(negedge clk);
      load = ld; advance = adv; test_mode = tm; key_in = kin;
      e.key = ek; e.idx = ei; e.use_key = uk; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin
      #(5ns * 5000);
      judge(1'b0, "watchdog", "timeout", "completion");
      done = 1'b1;
   end

   initial begin
      #7;
      judge(round_key == '0, "R1 key", $sformatf("%h", round_key), "0");
      judge(round_idx == '0, "R1 idx", $sformatf("%0d", round_idx), "0");
      @(negedge clk); rst_n = 1'b1;

      drive(1, 0, 0, K, ref_k[0], 0, 1, "R2 load");
      for (int i = 1; i <= 10; i++)
         drive(0, 1, 0, K, ref_k[i], 4'(i), 1, $sformatf("R3 round %0d", i));
      drive(0, 0, 0, ~K, ref_k[10], 10, 1, "R4 hold");
      drive(0, 1, 0, K, ref_k[0], 0, 1, "R5 mission wrap");
      drive(0, 1, 0, K, ref_k[1], 1, 1, "R7 rcon restart after wrap");
      drive(1, 1, 0, K, ref_k[0], 0, 1, "R2 load over advance");
      for (int i = 1; i <= 10; i++)
         drive(0, 1, 1, K, ref_k[i], 4'(i), 1, $sformatf("R3 test round %0d", i));
      drive(0, 1, 1, ~K, ref_k[10], 0, 1, "R6 test wrap keeps tenth key");
      for (int i = 1; i <= 10; i++)
         drive(0, 1, 1, ~K, '0, 4'(i), 0, $sformatf("R8 chained idx %0d", i));
      drive(0, 1, 1, ~K, '0, 0, 0, "R8 second wrap");
      drive(1, 0, 1, K, ref_k[0], 0, 1, "R2 load in test mode");
      drive(0, 1, 1, K, ref_k[1], 1, 1, "R7 rcon restart after load");
      drive(0, 0, 0, K, ref_k[1], 1, 1, "R4 idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      wait (done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule